// File: doc/BRIEF.md
# Clear-On-Read MAC Status Register

This block gathers single-cycle error and event pulses from an Ethernet MAC into one 64-bit status word that can only be read. Each event sets a sticky bit that stays set until the word is read. The read itself clears those bits, so software sees every event since its previous read.

Alongside the sticky bits, a 32-bit group of live status inputs, such as watermark flags, is placed in the low half of the word. These bits follow their inputs directly and are never latched or cleared. A statistics-counter overflow also records the 5-bit number of the counter that overflowed. In packet-FIFO mode there are no collisions and no statistics counters, so the collision and counter-overflow events are ignored in that mode.

The read-data output is combinational from the stored bits. A read strobe therefore returns the value held in that cycle, and the clear takes effect at the next clock edge.

Top module: `macStatusReg`

## Requirements
- R1: After reset every bit of `rdData` except the live field (bits 31:0) reads zero.
- R2: One cycle after an event pulse, its sticky bit reads 1. The bit positions are: receive FIFO underflow 40, receive FIFO overflow 41, transmit FIFO underflow 42, transmit FIFO overflow 43, late collision 44, excessive collision 45, counter overflow 46.
- R3: A cycle with `rdStrobe` high returns the bits held before the read. If no event arrives in that cycle, all sticky bits read 0 from the next cycle on.
- R4: A sticky bit whose event pulses in the same cycle as a read is still 1 after the read, so no event is lost.
- R5: A counter-overflow pulse sets bit 46 and loads `cntIndex` into bits 51:47. When overflows repeat, the field holds the index of the most recent one.
- R6: The index field (bits 51:47) reads zero whenever bit 46 is clear. A read that clears bit 46 also clears the field.
- R7: While `pktFifoMode` is high, late-collision, excessive-collision and counter-overflow pulses leave bits 44, 45, 46 and 51:47 unchanged. FIFO under/overflow events still latch in this mode.
- R8: Bits 31:0 equal `liveStatus` in the same cycle, whether or not a read is in progress.
- R9: Reserved bits 39:32 and 63:52 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | Status word is being read this cycle |
| pktFifoMode | input | 1 | Packet-FIFO mode: masks collision and counter events |
| evRxUnder | input | 1 | Receive FIFO underflow pulse |
| evRxOver | input | 1 | Receive FIFO overflow pulse |
| evTxUnder | input | 1 | Transmit FIFO underflow pulse |
| evTxOver | input | 1 | Transmit FIFO overflow pulse |
| evLateCol | input | 1 | Late collision pulse |
| evExcessCol | input | 1 | Excessive collision pulse (16th collision of one packet) |
| evCntOver | input | 1 | Statistics-counter overflow pulse |
| cntIndex | input | 5 | Number of the overflowing counter, valid with `evCntOver` |
| liveStatus | input | 32 | Non-latched status inputs |
| rdData | output | 64 | Status word |

## Verification
The assertions assume that `cntIndex` is meaningful only in cycles where `evCntOver` is high. They also assume that event inputs and `pktFifoMode` are steady around the clock edge and that reset is held for at least one edge. The stimulus changes all inputs shortly after each rising edge. It pulses `cntIndex` with fresh values only alongside overflow pulses and otherwise fills it with noise that must be ignored. The stimulus also switches packet-FIFO mode during runs of collision events to check that no bit is set while the mode is active.

// File: rtl/macsts_pkg.sv
package macsts_pkg;
  localparam int NUM_EV = 7;
  // event order matches sticky bit order within the word
  localparam int EV_RX_UNDER  = 0;
  localparam int EV_RX_OVER   = 1;
  localparam int EV_TX_UNDER  = 2;
  localparam int EV_TX_OVER   = 3;
  localparam int EV_LATE_COL  = 4;
  localparam int EV_EXCESS    = 5;
  localparam int EV_CNT_OVER  = 6;

  typedef struct packed {
    logic [NUM_EV-1:0] setMask;   // events allowed to set their sticky bit
    logic              clearAll;  // read in progress: clear at next edge
    logic              loadIdx;   // capture the counter index
  } strobe_t;
endpackage

// File: rtl/macsts_ctrl.sv
module macsts_ctrl
  import macsts_pkg::*;
(
  input  logic              rdStrobe,
  input  logic              pktFifoMode,
  input  logic [NUM_EV-1:0] evIn,
  output strobe_t           strobes
);
  logic [NUM_EV-1:0] modeMask;

  // events that cannot occur in packet-FIFO mode are gated off there
  always_comb begin
    modeMask = '1;
    if (pktFifoMode) begin
      modeMask[EV_LATE_COL] = 1'b0;
      modeMask[EV_EXCESS]   = 1'b0;
      modeMask[EV_CNT_OVER] = 1'b0;
    end
  end

  always_comb begin
    strobes.setMask  = evIn & modeMask;
    strobes.clearAll = rdStrobe;
    strobes.loadIdx  = evIn[EV_CNT_OVER] & modeMask[EV_CNT_OVER];
  end
endmodule

// File: rtl/macsts_dp.sv
module macsts_dp
  import macsts_pkg::*;
#(
  parameter int LIVE_W     = 32,
  parameter int IDX_W      = 5,
  parameter int WORD_W     = 64,
  parameter int STICKY_LSB = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [IDX_W-1:0]  idxIn,
  input  logic [LIVE_W-1:0] liveIn,
  output logic [WORD_W-1:0] word
);
  localparam int IDX_LSB = STICKY_LSB + NUM_EV;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [NUM_EV-1:0] sticky;
  logic [IDX_W-1:0]  idxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sticky <= '0;
    end else begin
      sticky <= (strobes.clearAll ? '0 : sticky) | strobes.setMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
    end else if (strobes.loadIdx) begin
      idxReg <= idxIn;
    end else if (strobes.clearAll) begin
      idxReg <= '0;
    end
  end

  always_comb begin
    word = '0;
    word[LIVE_W-1:0]                       = liveIn;
    word[STICKY_LSB +: NUM_EV]             = sticky;
    word[IDX_MSB:IDX_LSB]                  = idxReg;
  end

  // R2: an admitted event is visible next cycle
  p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setMask != '0 |=> ((sticky & $past(strobes.setMask)) == $past(strobes.setMask)));
  // R3: a read with no coincident event empties the sticky bits
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll && strobes.setMask == '0 |=> sticky == '0);
  // R4: bits only fall across a read
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearAll |=> ((sticky & $past(sticky)) == $past(sticky)));
  // R5: the index follows the latest overflow
  p_idx_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIdx |=> idxReg == $past(idxIn));
  // R6: index is zero while the overflow bit is clear
  p_idx_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !sticky[EV_CNT_OVER] |-> idxReg == '0);
endmodule

// File: rtl/macStatusReg.sv
module macStatusReg (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdStrobe,
  input  logic        pktFifoMode,
  input  logic        evRxUnder,
  input  logic        evRxOver,
  input  logic        evTxUnder,
  input  logic        evTxOver,
  input  logic        evLateCol,
  input  logic        evExcessCol,
  input  logic        evCntOver,
  input  logic [4:0]  cntIndex,
  input  logic [31:0] liveStatus,
  output logic [63:0] rdData
);
  import macsts_pkg::*;

  strobe_t           strobes;
  logic [NUM_EV-1:0] evIn;

  assign evIn = {evCntOver, evExcessCol, evLateCol,
                 evTxOver, evTxUnder, evRxOver, evRxUnder};

  macsts_ctrl u_ctrl (
    .rdStrobe   (rdStrobe),
    .pktFifoMode(pktFifoMode),
    .evIn       (evIn),
    .strobes    (strobes)
  );

  macsts_dp #(
    .LIVE_W    (32),
    .IDX_W     (5),
    .WORD_W    (64),
    .STICKY_LSB(40)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .idxIn  (cntIndex),
    .liveIn (liveStatus),
    .word   (rdData)
  );

  // R7: in packet-FIFO mode collision and counter bits never rise
  p_pkt_r7: assert property (@(posedge clk) disable iff (!rstN)
    pktFifoMode |=> !$rose(rdData[44]) && !$rose(rdData[45]) && !$rose(rdData[46]));
endmodule

// File: tb/test_macStatusReg.sv
`timescale 1ns/100ps
module test_macStatusReg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdStrobe = 1'b0;
  logic        pktFifoMode = 1'b0;
  logic [6:0]  ev = '0;
  logic [4:0]  cntIndex = '0;
  logic [31:0] liveStatus = '0;
  logic [63:0] rdData;

  int nTests = 0;
  int nFail  = 0;

  // behavioural reference state
  logic [6:0] mSticky = '0;
  logic [4:0] mIdx    = '0;

  always #2.5 clk = ~clk;

  macStatusReg i_macStatusReg (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .pktFifoMode(pktFifoMode),
    .evRxUnder(ev[0]), .evRxOver(ev[1]), .evTxUnder(ev[2]), .evTxOver(ev[3]),
    .evLateCol(ev[4]), .evExcessCol(ev[5]), .evCntOver(ev[6]),
    .cntIndex(cntIndex), .liveStatus(liveStatus), .rdData(rdData)
  );

  // reference update from the requirements
  always @(posedge clk) begin
    logic [6:0] allowed;
    if (!rstN) begin
      mSticky = '0;
      mIdx    = '0;
    end else begin
      allowed = pktFifoMode ? 7'b0001111 : 7'b1111111;
      if (rdStrobe) begin
        mSticky = '0;
        mIdx    = '0;
      end
      mSticky = mSticky | (ev & allowed);
      if (ev[6] && !pktFifoMode) mIdx = cntIndex;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-clock comparison, field by field
  always @(negedge clk) begin
    if (rstN) begin
      check("R8 live",     {32'b0, rdData[31:0]},  {32'b0, liveStatus});
      check("R9 reserved", {rdData[63:52], 44'b0, rdData[39:32]}, 64'b0);
      check("R2 sticky",   {57'b0, rdData[46:40]}, {57'b0, mSticky});
      check("R5 index",    {59'b0, rdData[51:47]}, {59'b0, mIdx});
    end
  end

  task automatic step(logic [6:0] e, logic rd, logic [4:0] idx);
    @(posedge clk);
    #1;
    ev = e; rdStrobe = rd; cntIndex = idx;
    liveStatus = $urandom;
  endtask

  task automatic idleTo(int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 5'($urandom));
  endtask

  // sample the output at the next falling edge
  task automatic peek(output logic [63:0] v);
    @(negedge clk);
    v = rdData;
  endtask

  initial begin : watchdog
    #(5ns * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    liveStatus = 32'hA5A5_0F0F;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R1 reset", rdData & ~64'hFFFF_FFFF, 64'b0);
    rstN = 1'b1;

    // R2: each event alone, then read to clear (R3)
    for (int b = 0; b < 7; b++) begin
      step(7'(1 << b), 1'b0, 5'(b + 3));
      step('0, 1'b0, 5'd0);
      peek(v);
      check("R2 single", {57'b0, v[46:40]}, {57'b0, 7'(1 << b)});
      step('0, 1'b1, 5'd0);
      peek(v);
      check("R3 old value on read", {57'b0, v[46:40]}, {57'b0, 7'(1 << b)});
      step('0, 1'b0, 5'd0);
      peek(v);
      check("R3 cleared", {45'b0, v[51:40], 7'b0}, 64'b0);
    end

    // R4: event coincides with read
    step(7'b0000011, 1'b0, 5'd0);
    step(7'b0000100, 1'b1, 5'd0);
    step('0, 1'b0, 5'd0);
    peek(v);
    check("R4 coincident kept", {57'b0, v[46:40]}, {57'b0, 7'b0000100});
    step('0, 1'b1, 5'd0);

    // R5: most recent index wins
    step(7'b1000000, 1'b0, 5'd7);
    step(7'b1000000, 1'b0, 5'd29);
    step('0, 1'b0, 5'd31);
    peek(v);
    check("R5 latest index", {59'b0, v[51:47]}, {59'b0, 5'd29});
    // R6: read clears index with bit
    step('0, 1'b1, 5'd0);
    step('0, 1'b0, 5'd0);
    peek(v);
    check("R6 index cleared", {58'b0, v[51:46]}, 64'b0);

    // R7: packet-FIFO mode masks collision and counter events
    pktFifoMode = 1'b1;
    step(7'b1110000, 1'b0, 5'd9);
    step(7'b1111111, 1'b0, 5'd9);
    step('0, 1'b0, 5'd0);
    peek(v);
    check("R7 pkt mode masked", {52'b0, v[51:40]}, {52'b0, 12'b0000_000_1111});
    pktFifoMode = 1'b0;
    step('0, 1'b1, 5'd0);
    step('0, 1'b0, 5'd0);

    // R8: live bits during a read
    step('0, 1'b1, 5'd0);
    peek(v);
    check("R8 live during read", {32'b0, v[31:0]}, {32'b0, liveStatus});

    // random traffic, compared every clock
    for (int i = 0; i < 3000; i++) begin
      pktFifoMode = ($urandom % 8) == 0;
      step(7'($urandom) & 7'($urandom), ($urandom % 5) == 0, 5'($urandom));
    end
    idleTo(3);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule